// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer arithmetic and logic stage of a small RISC core. One call takes an operation code, two 32-bit register operands, a 16-bit immediate field and an immediate-mode select. It returns the 32-bit result, a write enable for the destination register, new values for the four status flags (zero, sign, carry, overflow) and a mask that names the flags the operation updates. The consumer overwrites only the masked flags in its status word and keeps every other status bit.

The operations are move, add, subtract, reverse subtract, OR, AND, XOR, NOT, move-add of a sign-extended 16-bit immediate and move-high. Each operation has its own flag policy. Arithmetic updates all four flags. Logic leaves carry alone and clears overflow, and AND with an immediate also clears sign. The move-type operations touch no flag. Outputs are registered, so a result appears one clock after its inputs.

Top module: `alu_flags_core`

## Requirements
- R1: op_i codes are 0 move, 1 add, 2 subtract, 3 reverse subtract, 4 OR, 5 AND, 6 XOR, 7 NOT, 8 move-add, 9 move-high. Add returns src_b_i plus the selected operand. It updates all four flags (mask 4'b1111), and Z is set exactly when the 32-bit result is zero. Flag and mask bits are bit0 Z, bit1 S, bit2 CY, bit3 OV.
- R2: For add, CY is the unsigned carry out of bit 31. OV is set when both operands have the same sign and the result sign differs from it.
- R3: Subtract returns src_b_i minus the operand. Reverse subtract returns the operand minus src_b_i. In both, CY is set when the subtrahend is larger than the minuend as unsigned values. OV is set when the operand signs differ and the result sign differs from the minuend sign.
- R4: imm_mode_i picks the operand: 0 src_a_i; 1 imm_i[4:0] sign-extended; 2 imm_i sign-extended for add, subtract and reverse subtract, and zero-extended for OR, AND and XOR; 3 behaves as 0.
- R5: OR, XOR and NOT (NOT inverts the selected operand) set Z and S from the result and clear OV. They leave CY untouched, so their mask is 4'b1011.
- R6: AND with the register operand follows R5. AND with an immediate (mode 1 or 2) updates Z, clears S and OV, and leaves CY untouched (mask 4'b1011, S value 0).
- R7: Move writes the selected operand unchanged with mask 4'b0000.
- R8: Move-add returns src_b_i plus imm_i sign-extended. Move-high returns src_b_i plus imm_i placed in bits 31:16. Both ignore imm_mode_i, write, and have mask 4'b0000.
- R9: Codes 10 to 15 are illegal. They give write enable 0, result 0, flags 0 and mask 0.
- R10: All outputs change on the first rising clock edge after their inputs are applied. Reset (rst_n low) forces every output to 0.
- R11: A flag bit whose mask bit is 0 is driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand and add base |
| imm_i | input | 16 | Immediate field |
| imm_mode_i | input | 2 | Operand source and extension select |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | New flag values {OV, CY, S, Z} |
| flag_mask_o | output | 4 | Flags to overwrite {OV, CY, S, Z} |

## Verification
Additions are driven with operand pairs that give a zero result with carry, a signed overflow without carry, and a plain sum. These separate the carry rule from the overflow rule. Subtractions use a minuend below the subtrahend and a most-negative minuend, which pulls borrow apart from overflow, and the reverse form is run with the same values to expose a swapped operand order. Immediates with bit 15 or bit 4 set tell sign extension from zero extension in each mode. A sweep over every code and mode against an independent model covers the illegal codes and the reserved mode.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
    parameter int DATA_W  = 32;
    parameter int IMM_W   = 16;
    parameter int SHORT_W = 5;
    parameter int FLAG_W  = 4;

    localparam int FZ  = 0;
    localparam int FS  = 1;
    localparam int FCY = 2;
    localparam int FOV = 3;

    typedef enum logic [3:0] {
        OP_MOV   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBR  = 4'd3,
        OP_OR    = 4'd4,
        OP_AND   = 4'd5,
        OP_XOR   = 4'd6,
        OP_NOT   = 4'd7,
        OP_MOVEA = 4'd8,
        OP_MOVHI = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        IM_REG   = 2'd0,
        IM_SHORT = 2'd1,
        IM_WIDE  = 2'd2,
        IM_RSVD  = 2'd3
    } imm_mode_e;

    typedef enum logic [1:0] {
        LG_OR  = 2'd0,
        LG_AND = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] mask;
    } alu_out_t;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_flags_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int IW  = IMM_W,
    parameter int SW  = SHORT_W
) (
    input  logic [W-1:0]  reg_i,
    input  logic [IW-1:0] imm_i,
    input  logic [1:0]    mode_i,
    input  logic          zext_i,
    output logic [W-1:0]  opnd_o,
    output logic          is_imm_o
);
    localparam int SPAD = W - SW;
    localparam int WPAD = W - IW;

    logic [W-1:0] short_sx;
    logic [W-1:0] wide_sx;
    logic [W-1:0] wide_zx;

    assign short_sx = {{SPAD{imm_i[SW-1]}}, imm_i[SW-1:0]};
    assign wide_sx  = {{WPAD{imm_i[IW-1]}}, imm_i};
    assign wide_zx  = {{WPAD{1'b0}}, imm_i};

    always_comb begin
        opnd_o   = reg_i;
        is_imm_o = 1'b0;
        case (imm_mode_e'(mode_i))
            IM_SHORT: begin
                opnd_o   = short_sx;
                is_imm_o = 1'b1;
            end
            IM_WIDE: begin
                opnd_o   = zext_i ? wide_zx : wide_sx;
                is_imm_o = 1'b1;
            end
            default: begin
                opnd_o   = reg_i;
                is_imm_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         ov_o
);
    logic [W:0]   full;
    logic [W-1:0] y_eff;
    logic         carry;

    assign y_eff = sub_i ? ~y_i : y_i;
    assign full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, sub_i};
    assign sum_o = full[W-1:0];
    assign carry = full[W];

    always_comb begin
        if (sub_i) begin
            cy_o = ~carry;
            ov_o = (x_i[W-1] != y_i[W-1]) && (sum_o[W-1] != x_i[W-1]);
        end else begin
            cy_o = carry;
            ov_o = (x_i[W-1] == y_i[W-1]) && (sum_o[W-1] != x_i[W-1]);
        end
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int W = 32
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] res_o
);
    import alu_flags_pkg::*;

    always_comb begin
        case (logic_sel_e'(sel_i))
            LG_OR:   res_o = x_i | y_i;
            LG_AND:  res_o = x_i & y_i;
            LG_XOR:  res_o = x_i ^ y_i;
            default: res_o = ~y_i;
        endcase
    end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
    import alu_flags_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  src_a_i,
    input  logic [W-1:0]  src_b_i,
    input  logic [IW-1:0] imm_i,
    input  logic [1:0]    imm_mode_i,
    output logic [W-1:0]  result_o,
    output logic          wr_en_o,
    output logic [3:0]    flags_o,
    output logic [3:0]    flag_mask_o
);
    localparam int HPAD = W - IW;
    localparam logic [3:0] MASK_ALL   = 4'b1111;
    localparam logic [3:0] MASK_LOGIC = 4'b1011;

    alu_op_e  op_e;
    logic     zext;
    logic [W-1:0] opnd;
    logic     opnd_imm;
    logic [W-1:0] add_x_d;
    logic [W-1:0] add_y_d;
    logic     add_sub_d;
    logic [W-1:0] sum;
    logic     sum_cy;
    logic     sum_ov;
    logic [1:0] lg_sel_d;
    logic [W-1:0] lg_res;
    alu_out_t out_d;
    alu_out_t out_q;

    assign op_e = alu_op_e'(op_i);
    assign zext = (op_e == OP_OR) || (op_e == OP_AND) || (op_e == OP_XOR);

    alu_operand_sel #(.W(W), .IW(IW), .SW(SHORT_W)) u_opsel (
        .reg_i    (src_a_i),
        .imm_i    (imm_i),
        .mode_i   (imm_mode_i),
        .zext_i   (zext),
        .opnd_o   (opnd),
        .is_imm_o (opnd_imm)
    );

    // adder operand routing
    always_comb begin
        add_x_d   = src_b_i;
        add_y_d   = opnd;
        add_sub_d = 1'b0;
        case (op_e)
            OP_SUB:   add_sub_d = 1'b1;
            OP_SUBR: begin
                add_x_d   = opnd;
                add_y_d   = src_b_i;
                add_sub_d = 1'b1;
            end
            OP_MOVEA: add_y_d = {{HPAD{imm_i[IW-1]}}, imm_i};
            OP_MOVHI: add_y_d = {imm_i, {HPAD{1'b0}}};
            default: ;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .x_i   (add_x_d),
        .y_i   (add_y_d),
        .sub_i (add_sub_d),
        .sum_o (sum),
        .cy_o  (sum_cy),
        .ov_o  (sum_ov)
    );

    always_comb begin
        case (op_e)
            OP_AND:  lg_sel_d = 2'(LG_AND);
            OP_XOR:  lg_sel_d = 2'(LG_XOR);
            OP_NOT:  lg_sel_d = 2'(LG_NOT);
            default: lg_sel_d = 2'(LG_OR);
        endcase
    end

    alu_logic_unit #(.W(W)) u_logic (
        .sel_i (lg_sel_d),
        .x_i   (src_b_i),
        .y_i   (opnd),
        .res_o (lg_res)
    );

    // next-state computation
    always_comb begin
        out_d = '0;
        case (op_e)
            OP_MOV: begin
                out_d.result = opnd;
                out_d.wr_en  = 1'b1;
            end
            OP_ADD, OP_SUB, OP_SUBR: begin
                out_d.result     = sum;
                out_d.wr_en      = 1'b1;
                out_d.mask       = MASK_ALL;
                out_d.flags[FZ]  = (sum == '0);
                out_d.flags[FS]  = sum[W-1];
                out_d.flags[FCY] = sum_cy;
                out_d.flags[FOV] = sum_ov;
            end
            OP_OR, OP_AND, OP_XOR, OP_NOT: begin
                out_d.result     = lg_res;
                out_d.wr_en      = 1'b1;
                out_d.mask       = MASK_LOGIC;
                out_d.flags[FZ]  = (lg_res == '0);
                out_d.flags[FS]  = (op_e == OP_AND && opnd_imm) ? 1'b0 : lg_res[W-1];
                out_d.flags[FOV] = 1'b0;
            end
            OP_MOVEA, OP_MOVHI: begin
                out_d.result = sum;
                out_d.wr_en  = 1'b1;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o    = out_q.result;
    assign wr_en_o     = out_q.wr_en;
    assign flags_o     = out_q.flags;
    assign flag_mask_o = out_q.mask;

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd9) |=> (!wr_en_o && flag_mask_o == 4'b0000 && result_o == '0));

    // R11
    masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~flag_mask_o) == 4'b0000));

    // R5
    logic_cy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd6 || op_i == 4'd7) |=> (flag_mask_o == 4'b1011 && !flags_o[3]));

    // R7
    move_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i == 4'd8 || op_i == 4'd9) |=> (flag_mask_o == 4'b0000 && wr_en_o));

    // R1
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_mask_o[0] |-> (flags_o[0] == (result_o == '0)));

    // R2
    add_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 && imm_mode_i == 2'd0 && src_a_i[W-1] != src_b_i[W-1]) |=> !flags_o[3]);

    // R3
    sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2 && imm_mode_i == 2'd0 && src_a_i == src_b_i) |=> (flags_o[0] && !flags_o[2]));

    // R6
    and_imm_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5 && (imm_mode_i == 2'd1 || imm_mode_i == 2'd2)) |=> !flags_o[1]);
endmodule

// File: tb/tb_alu_flags_core.sv
module tb_alu_flags_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic [1:0]  mode = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags;
    logic [3:0]  mask;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_flags_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_a_i(a), .src_b_i(b),
        .imm_i(imm), .imm_mode_i(mode), .result_o(result), .wr_en_o(wr_en),
        .flags_o(flags), .flag_mask_o(mask)
    );

    logic [31:0] e_res;
    logic        e_wr;
    logic [3:0]  e_fl;
    logic [3:0]  e_mk;

    // independent model of the requirements; flags {OV,CY,S,Z}
    task automatic model(input logic [3:0] o, input logic [31:0] ra, input logic [31:0] rb,
                         input logic [15:0] im, input logic [1:0] md);
        logic [31:0] x;
        logic [32:0] t;
        logic [31:0] r;
        if (md == 2'd1)      x = {{27{im[4]}}, im[4:0]};
        else if (md == 2'd2) x = (o >= 4'd4 && o <= 4'd6) ? {16'h0, im} : {{16{im[15]}}, im};
        else                 x = ra;
        e_res = '0; e_wr = 1'b0; e_fl = '0; e_mk = '0;
        case (o)
            4'd0: begin e_res = x; e_wr = 1'b1; end
            4'd1: begin
                t = {1'b0, rb} + {1'b0, x}; r = t[31:0];
                e_res = r; e_wr = 1'b1; e_mk = 4'hF;
                e_fl = {(rb[31] == x[31]) && (r[31] != rb[31]), t[32], r[31], r == 0};
            end
            4'd2: begin
                r = rb - x; e_res = r; e_wr = 1'b1; e_mk = 4'hF;
                e_fl = {(rb[31] != x[31]) && (r[31] != rb[31]), rb < x, r[31], r == 0};
            end
            4'd3: begin
                r = x - rb; e_res = r; e_wr = 1'b1; e_mk = 4'hF;
                e_fl = {(rb[31] != x[31]) && (r[31] != x[31]), x < rb, r[31], r == 0};
            end
            4'd4, 4'd5, 4'd6, 4'd7: begin
                r = (o == 4'd4) ? (rb | x) : (o == 4'd5) ? (rb & x) : (o == 4'd6) ? (rb ^ x) : ~x;
                e_res = r; e_wr = 1'b1; e_mk = 4'b1011;
                e_fl = {2'b00, (o == 4'd5 && (md == 2'd1 || md == 2'd2)) ? 1'b0 : r[31], r == 0};
            end
            4'd8: begin e_res = rb + {{16{im[15]}}, im}; e_wr = 1'b1; end
            4'd9: begin e_res = rb + {im, 16'h0}; e_wr = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag, input logic [31:0] er, input logic ew,
                           input logic [3:0] ef, input logic [3:0] em);
        checks++;
        if (result !== er || wr_en !== ew || flags !== ef || mask !== em) begin
            fails++;
            $display("FAIL %s op=%0d mode=%0d: got res=%h wr=%b fl=%b mk=%b exp res=%h wr=%b fl=%b mk=%b",
                     tag, op, mode, result, wr_en, flags, mask, er, ew, ef, em);
        end
    endtask

    task automatic run_exp(input string tag, input logic [3:0] o, input logic [31:0] ra,
                           input logic [31:0] rb, input logic [15:0] im, input logic [1:0] md,
                           input logic [31:0] er, input logic ew, input logic [3:0] ef,
                           input logic [3:0] em);
        @(negedge clk);
        op = o; a = ra; b = rb; imm = im; mode = md;
        @(negedge clk);
        compare(tag, er, ew, ef, em);
    endtask

    task automatic run(input string tag, input logic [3:0] o, input logic [31:0] ra,
                       input logic [31:0] rb, input logic [15:0] im, input logic [1:0] md);
        model(o, ra, rb, im, md);
        run_exp(tag, o, ra, rb, im, md, e_res, e_wr, e_fl, e_mk);
    endtask

    task automatic t_reset;
        // R10: outputs zero under reset
        @(negedge clk);
        op = 4'd1; a = 32'h1; b = 32'h2;
        @(negedge clk);
        compare("R10 reset", 32'h0, 1'b0, 4'h0, 4'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_add;
        run_exp("R1 add zero+carry", 4'd1, 32'h1, 32'hFFFF_FFFF, 16'h0, 2'd0, 32'h0, 1'b1, 4'b0101, 4'hF);
        run_exp("R2 add overflow", 4'd1, 32'h1, 32'h7FFF_FFFF, 16'h0, 2'd0, 32'h8000_0000, 1'b1, 4'b1010, 4'hF);
        run_exp("R1 add plain", 4'd1, 32'h10, 32'h20, 16'h0, 2'd0, 32'h30, 1'b1, 4'b0000, 4'hF);
        run_exp("R4 add short imm", 4'd1, 32'h0, 32'h5, 16'h001F, 2'd1, 32'h4, 1'b1, 4'b0100, 4'hF);
        run_exp("R4 add wide sext", 4'd1, 32'h0, 32'h0, 16'h8000, 2'd2, 32'hFFFF_8000, 1'b1, 4'b0010, 4'hF);
        run_exp("R4 reserved mode as reg", 4'd1, 32'h3, 32'h4, 16'h7FFF, 2'd3, 32'h7, 1'b1, 4'b0000, 4'hF);
    endtask

    task automatic t_sub;
        run_exp("R3 sub borrow", 4'd2, 32'h5, 32'h3, 16'h0, 2'd0, 32'hFFFF_FFFE, 1'b1, 4'b0110, 4'hF);
        run_exp("R3 sub overflow", 4'd2, 32'h1, 32'h8000_0000, 16'h0, 2'd0, 32'h7FFF_FFFF, 1'b1, 4'b1000, 4'hF);
        run_exp("R3 subr order", 4'd3, 32'h5, 32'h3, 16'h0, 2'd0, 32'h2, 1'b1, 4'b0000, 4'hF);
        run_exp("R3 sub equal", 4'd2, 32'hABCD, 32'hABCD, 16'h0, 2'd0, 32'h0, 1'b1, 4'b0001, 4'hF);
    endtask

    task automatic t_logic;
        run_exp("R5 or wide zext", 4'd4, 32'h0, 32'h0, 16'h8000, 2'd2, 32'h0000_8000, 1'b1, 4'b0000, 4'b1011);
        run_exp("R5 xor zero", 4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 2'd0, 32'h0, 1'b1, 4'b0001, 4'b1011);
        run_exp("R5 not", 4'd7, 32'h0, 32'h1234, 16'h0, 2'd0, 32'hFFFF_FFFF, 1'b1, 4'b0010, 4'b1011);
        run_exp("R6 and reg sign", 4'd5, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 2'd0, 32'h8000_0000, 1'b1, 4'b0010, 4'b1011);
        run_exp("R6 and imm", 4'd5, 32'h0, 32'h8000_0001, 16'hFFFF, 2'd2, 32'h1, 1'b1, 4'b0000, 4'b1011);
        run_exp("R6 and imm zero", 4'd5, 32'h0, 32'h8000_0000, 16'h0000, 2'd2, 32'h0, 1'b1, 4'b0001, 4'b1011);
        run_exp("R6 and short sign cleared", 4'd5, 32'h0, 32'hFFFF_FFFF, 16'h0010, 2'd1, 32'hFFFF_FFF0, 1'b1, 4'b0000, 4'b1011);
    endtask

    task automatic t_moves;
        run_exp("R7 mov short", 4'd0, 32'h0, 32'h0, 16'h0010, 2'd1, 32'hFFFF_FFF0, 1'b1, 4'h0, 4'h0);
        run_exp("R7 mov reg", 4'd0, 32'h8000_0000, 32'h1, 16'h0, 2'd0, 32'h8000_0000, 1'b1, 4'h0, 4'h0);
        run_exp("R8 movea", 4'd8, 32'h0, 32'h10, 16'hFFFF, 2'd1, 32'hF, 1'b1, 4'h0, 4'h0);
        run_exp("R8 movhi", 4'd9, 32'h0, 32'h1, 16'h1234, 2'd2, 32'h1234_0001, 1'b1, 4'h0, 4'h0);
    endtask

    task automatic t_illegal;
        run_exp("R9 illegal 12", 4'd12, 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 2'd0, 32'h0, 1'b0, 4'h0, 4'h0);
        run_exp("R9 illegal 15", 4'd15, 32'h0, 32'h0, 16'h0, 2'd2, 32'h0, 1'b0, 4'h0, 4'h0);
    endtask

    task automatic t_latency;
        // R10: new inputs do not reach outputs before the next rising edge
        run_exp("R10 setup", 4'd1, 32'h1, 32'h1, 16'h0, 2'd0, 32'h2, 1'b1, 4'b0000, 4'hF);
        op = 4'd1; a = 32'h7; b = 32'h8;
        #1;
        compare("R10 before edge", 32'h2, 1'b1, 4'b0000, 4'hF);
        @(negedge clk);
        compare("R10 after edge", 32'hF, 1'b1, 4'b0000, 4'hF);
    endtask

    task automatic t_sweep;
        // R11 and all ops/modes against the model
        logic [31:0] s = 32'hACE1_2345;
        for (int o = 0; o < 16; o++) begin
            for (int m = 0; m < 4; m++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] va;
                    logic [31:0] vb;
                    s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
                    va = s;
                    s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
                    vb = (k == 0) ? va : s;
                    run("R11 sweep", 4'(o), va, vb, s[15:0] ^ va[31:16], 2'(m));
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_moves();
        t_illegal();
        t_latency();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule